// File: doc/BRIEF.md
# PC Card ATA Task-File Decoder

This block sits behind the common-memory window of a PC Card host port and turns each host access into a read or write of an ATA task file: seven byte-wide registers plus a 16-bit data port. It watches the two card-enable strobes, the register-select strobe, the low address bits and the read and write strobes. From these it works out whether the host is making a word access, a low-lane byte access or an access to the odd byte only, and places every register on the correct half of the 16-bit host data bus.

Two task-file offsets hold one register for reads and a different one for writes. Reads return the error and status bytes supplied by the drive controller. Writes load the features and command bytes. A command write sends a single-cycle strobe to the controller. The data port does not store anything. It passes whole words to an external sector buffer through a push/pop handshake. Byte-wide data-port traffic is paired into 16-bit words by a low/high byte toggle.

The host strobes are treated as synchronous to `clk`. A write takes effect on the first clock edge that sees the write strobe low. A data-port read consumes its buffer word on the first clock edge that sees the read strobe high again.

Top module: `ata_taskfile_decoder`

## Requirements
- R1: An access is decoded only when `regN` is 1, `hostAddr[10]` is 0 and at least one card enable is low. Address bits 9:4 are ignored. In every other case `hostDataOe` stays 0 and a write changes no register.
- R2: Word mode (both card enables low) selects a register pair with `hostAddr[3:1]`, the even register on bits 7:0 and the odd one on bits 15:8. The pairs are: 1 = sector count / sector number, 2 = cylinder low / cylinder high, 3 = drive-head / status-command.
- R3: Byte mode (`ce1N`=0, `ce2N`=1) places the register at offset `hostAddr[3:0]` on bits 7:0. The offsets are: 1 error-features, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive-head, 7 status-command. Bits 15:8 read 0xFF.
- R4: Odd-only mode (`ce1N`=1, `ce2N`=0) uses bits 15:8. Offsets 0 and 1 both select error-features, and offsets 3, 5 and 7 select sector number, cylinder high and status-command. Bits 7:0 read 0xFF.
- R5: A read of error-features returns `errorIn` and a write loads `featuresOut`. A read of status-command returns `statusIn` and a write loads `cmdOut`.
- R6: In word mode, pairs 0 and 4 (offsets 0, 1, 8 and 9) are the data port. A read returns `bufRdData` and pulses `bufRdPop` for one cycle, one clock after the read strobe rises. A write pulses `bufWrPush` for one cycle with `bufWrData` equal to the host word.
- R7: Byte-wide data accesses go through a byte toggle that is 0 after reset. These are offsets 0, 8 and 9 in byte mode and offset 9 in odd-only mode. With the toggle at 0, a write is held and a read returns `bufRdData[7:0]`. With the toggle at 1, a write pushes {this byte, held byte} and a read returns `bufRdData[15:8]` and then pops. Each such access flips the toggle.
- R8: A write to status-command raises `cmdStrobe` for exactly one cycle, in the cycle after the write edge, with `cmdOut` already showing the new code. The write also clears the byte toggle.
- R9: A decoded read of an offset that maps to no register returns 0xFF on that lane.
- R10: After reset all task registers read 0, the strobes are low and the byte toggle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ce1N | input | 1 | Card enable for the low lane, active low |
| ce2N | input | 1 | Card enable for the high lane, active low |
| regN | input | 1 | Register-select strobe, 1 selects common memory |
| hostAddr | input | 11 | Host address bits 10:0 |
| oeN | input | 1 | Host read strobe, active low |
| weN | input | 1 | Host write strobe, active low |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data |
| hostDataOe | output | 1 | Drive enable for host read data |
| errorIn | input | 8 | Error byte from the controller |
| statusIn | input | 8 | Status byte from the controller |
| featuresOut | output | 8 | Features register |
| secCountOut | output | 8 | Sector count register |
| secNumOut | output | 8 | Sector number register |
| cylLowOut | output | 8 | Cylinder low register |
| cylHighOut | output | 8 | Cylinder high register |
| drvHeadOut | output | 8 | Drive/head register |
| cmdOut | output | 8 | Command register |
| cmdStrobe | output | 1 | One-cycle pulse after a command write |
| bufRdData | input | 16 | Word at the head of the sector buffer |
| bufRdPop | output | 1 | Consume the head buffer word |
| bufWrData | output | 16 | Word pushed into the buffer |
| bufWrPush | output | 1 | Push strobe toward the buffer |

## Verification
The bench targets lane steering. It runs the same offset in all three card-enable combinations and expects the register on a different lane each time, with 0xFF on the idle lane. A design that ignored the odd-only remapping would return cylinder low at odd offset 5, or put offset 0 on the data port instead of on error-features. The bench checks byte-wide data-port traffic for both the word it assembles and the number of pops. A toggle that missed a flip would push bytes swapped or pop twice per word. A toggle that survived a command write would return the high byte on the next byte read. The bench also checks that offsets with address bits 9:4 set still decode, and that accesses with the wrong register-select or space bit leave both the bus and the registers untouched.

// File: rtl/tfdec_pkg.sv
package tfdec_pkg;

  // Lane selector: values 1..7 follow the task-file offsets; 8/9 are data bytes.
  typedef enum logic [3:0] {
    SEL_ERRFEAT = 4'd1,
    SEL_SECCNT  = 4'd2,
    SEL_SECNUM  = 4'd3,
    SEL_CYLLO   = 4'd4,
    SEL_CYLHI   = 4'd5,
    SEL_DRVHD   = 4'd6,
    SEL_STATCMD = 4'd7,
    SEL_DLO     = 4'd8,
    SEL_DHI     = 4'd9,
    SEL_NONE    = 4'd15
  } laneSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     wrEn;
    logic     rdPop;
    laneSel_t loSel;
    laneSel_t hiSel;
  } ctrl_t;

endpackage

// File: rtl/tfdec_ctrl.sv
module tfdec_ctrl
  import tfdec_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              regN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              oeN,
  input  logic              weN,
  output ctrl_t             ctrl,
  output logic              hostDataOe
);

  localparam int SPACE_BIT = ADDR_W - 1;
  localparam int OFS_W     = 4;

  logic           oeNQ, weNQ, toggleQ;
  laneSel_t       rdLoQ, rdHiQ;
  laneSel_t       loSel, hiSel, dataByteSel;
  logic [OFS_W-1:0] ofs;
  logic           accessOk, wrStart, rdEnd;
  logic           loData, hiData, byteData, cmdWrite;
  logic           loDataQ, hiDataQ, byteDataQ;
  laneSel_t       dataSel, dataSelQ;
  logic           unusedAddrBits;

  assign ofs            = hostAddr[OFS_W-1:0];
  assign unusedAddrBits = ^hostAddr[SPACE_BIT-1:OFS_W];
  assign accessOk       = regN & ~hostAddr[SPACE_BIT] & (~ce1N | ~ce2N);
  assign dataByteSel    = toggleQ ? SEL_DHI : SEL_DLO;
  assign wrStart        = ~weN & weNQ;
  assign rdEnd          = oeN & ~oeNQ;

  // Lane decode
  always_comb begin
    loSel = SEL_NONE;
    hiSel = SEL_NONE;
    if (accessOk) begin
      if (!ce1N && !ce2N) begin
        case (ofs[OFS_W-1:1])
          3'd0, 3'd4: begin loSel = SEL_DLO;    hiSel = SEL_DHI;     end
          3'd1:       begin loSel = SEL_SECCNT; hiSel = SEL_SECNUM;  end
          3'd2:       begin loSel = SEL_CYLLO;  hiSel = SEL_CYLHI;   end
          3'd3:       begin loSel = SEL_DRVHD;  hiSel = SEL_STATCMD; end
          default:    ;
        endcase
      end else if (!ce1N) begin
        case (ofs)
          4'd0, 4'd8, 4'd9: loSel = dataByteSel;
          4'd1:    loSel = SEL_ERRFEAT;
          4'd2:    loSel = SEL_SECCNT;
          4'd3:    loSel = SEL_SECNUM;
          4'd4:    loSel = SEL_CYLLO;
          4'd5:    loSel = SEL_CYLHI;
          4'd6:    loSel = SEL_DRVHD;
          4'd7:    loSel = SEL_STATCMD;
          default: ;
        endcase
      end else begin
        case (ofs)
          4'd0, 4'd1: hiSel = SEL_ERRFEAT;
          4'd3:    hiSel = SEL_SECNUM;
          4'd5:    hiSel = SEL_CYLHI;
          4'd7:    hiSel = SEL_STATCMD;
          4'd9:    hiSel = dataByteSel;
          default: ;
        endcase
      end
    end
  end

  assign loData   = (loSel == SEL_DLO) || (loSel == SEL_DHI);
  assign hiData   = (hiSel == SEL_DLO) || (hiSel == SEL_DHI);
  assign byteData = loData ^ hiData;
  assign dataSel  = loData ? loSel : hiSel;
  assign cmdWrite = (loSel == SEL_STATCMD) || (hiSel == SEL_STATCMD);

  assign loDataQ   = (rdLoQ == SEL_DLO) || (rdLoQ == SEL_DHI);
  assign hiDataQ   = (rdHiQ == SEL_DLO) || (rdHiQ == SEL_DHI);
  assign byteDataQ = loDataQ ^ hiDataQ;
  assign dataSelQ  = loDataQ ? rdLoQ : rdHiQ;

  always_comb begin
    ctrl.wrEn  = wrStart & accessOk;
    ctrl.rdPop = rdEnd & ((rdLoQ == SEL_DHI) || (rdHiQ == SEL_DHI));
    ctrl.loSel = loSel;
    ctrl.hiSel = hiSel;
  end

  assign hostDataOe = ~oeN & accessOk;

  // Strobe history and read-lane capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeNQ  <= 1'b1;
      weNQ  <= 1'b1;
      rdLoQ <= SEL_NONE;
      rdHiQ <= SEL_NONE;
    end else begin
      oeNQ <= oeN;
      weNQ <= weN;
      if (!oeN) begin
        rdLoQ <= loSel;
        rdHiQ <= hiSel;
      end
    end
  end

  // Byte packing toggle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleQ <= 1'b0;
    end else if (ctrl.wrEn && cmdWrite) begin
      toggleQ <= 1'b0;
    end else if (ctrl.wrEn && byteData) begin
      toggleQ <= (dataSel == SEL_DLO);
    end else if (rdEnd && byteDataQ) begin
      toggleQ <= (dataSelQ == SEL_DLO);
    end
  end

  AST_BYTE_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!ce1N && ce2N) |-> (ctrl.hiSel == SEL_NONE)); // R3

  AST_ODD_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (ce1N && !ce2N) |-> (ctrl.loSel == SEL_NONE)); // R4

  AST_NO_ACCESS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!regN || hostAddr[SPACE_BIT] || (ce1N && ce2N)) |-> !ctrl.wrEn); // R1

  AST_CMD_CLEARS_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.wrEn && cmdWrite) |=> !toggleQ); // R8

  AST_POP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.rdPop |-> ($past(oeN) == 1'b0)); // R6

endmodule

// File: rtl/tfdec_datapath.sv
module tfdec_datapath
  import tfdec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [2*BYTE_W-1:0] hostDataIn,
  output logic [2*BYTE_W-1:0] hostDataOut,
  input  logic [BYTE_W-1:0]   errorIn,
  input  logic [BYTE_W-1:0]   statusIn,
  output logic [BYTE_W-1:0]   featuresOut,
  output logic [BYTE_W-1:0]   secCountOut,
  output logic [BYTE_W-1:0]   secNumOut,
  output logic [BYTE_W-1:0]   cylLowOut,
  output logic [BYTE_W-1:0]   cylHighOut,
  output logic [BYTE_W-1:0]   drvHeadOut,
  output logic [BYTE_W-1:0]   cmdOut,
  output logic                cmdStrobe,
  input  logic [2*BYTE_W-1:0] bufRdData,
  output logic                bufRdPop,
  output logic [2*BYTE_W-1:0] bufWrData,
  output logic                bufWrPush
);

  localparam int WORD_W  = 2 * BYTE_W;
  localparam int NUM_REG = 7;

  logic [BYTE_W-1:0] taskQ [1:NUM_REG];
  logic [BYTE_W-1:0] holdQ;
  logic [BYTE_W-1:0] loByte, hiByte, loRead, hiRead;
  logic              pushNow, holdLo, holdHi, cmdNow;
  logic [WORD_W-1:0] pushWord;

  assign loByte = hostDataIn[BYTE_W-1:0];
  assign hiByte = hostDataIn[WORD_W-1:BYTE_W];

  // Task registers: index r matches the lane selector value r
  for (genvar r = 1; r <= NUM_REG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        taskQ[r] <= '0;
      end else if (ctrl.wrEn) begin
        if (ctrl.loSel == laneSel_t'(4'(r)))      taskQ[r] <= loByte;
        else if (ctrl.hiSel == laneSel_t'(4'(r))) taskQ[r] <= hiByte;
      end
    end
  end

  function automatic logic [BYTE_W-1:0] laneValue(input laneSel_t sel);
    case (sel)
      SEL_ERRFEAT: return errorIn;
      SEL_SECCNT:  return taskQ[2];
      SEL_SECNUM:  return taskQ[3];
      SEL_CYLLO:   return taskQ[4];
      SEL_CYLHI:   return taskQ[5];
      SEL_DRVHD:   return taskQ[6];
      SEL_STATCMD: return statusIn;
      SEL_DLO:     return bufRdData[BYTE_W-1:0];
      SEL_DHI:     return bufRdData[WORD_W-1:BYTE_W];
      default:     return '1;
    endcase
  endfunction

  always_comb begin
    loRead      = laneValue(ctrl.loSel);
    hiRead      = laneValue(ctrl.hiSel);
    hostDataOut = {hiRead, loRead};
  end

  // Data-port write assembly
  assign pushNow  = ctrl.wrEn && ((ctrl.loSel == SEL_DHI) || (ctrl.hiSel == SEL_DHI));
  assign pushWord = {(ctrl.hiSel == SEL_DHI) ? hiByte : loByte,
                     (ctrl.loSel == SEL_DLO) ? loByte : holdQ};
  assign holdLo   = ctrl.wrEn && (ctrl.loSel == SEL_DLO) && (ctrl.hiSel != SEL_DHI);
  assign holdHi   = ctrl.wrEn && (ctrl.hiSel == SEL_DLO);
  assign cmdNow   = ctrl.wrEn && ((ctrl.loSel == SEL_STATCMD) || (ctrl.hiSel == SEL_STATCMD));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ     <= '0;
      bufWrPush <= 1'b0;
      bufWrData <= '0;
      bufRdPop  <= 1'b0;
      cmdStrobe <= 1'b0;
    end else begin
      if (holdLo)      holdQ <= loByte;
      else if (holdHi) holdQ <= hiByte;
      bufWrPush <= pushNow;
      if (pushNow) bufWrData <= pushWord;
      bufRdPop  <= ctrl.rdPop;
      cmdStrobe <= cmdNow;
    end
  end

  assign featuresOut = taskQ[1];
  assign secCountOut = taskQ[2];
  assign secNumOut   = taskQ[3];
  assign cylLowOut   = taskQ[4];
  assign cylHighOut  = taskQ[5];
  assign drvHeadOut  = taskQ[6];
  assign cmdOut      = taskQ[7];

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |=> !cmdStrobe); // R8

  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bufWrPush |=> !bufWrPush); // R6

  AST_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    bufRdPop |=> !bufRdPop); // R7

  AST_IDLE_LANE_FF: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.loSel == SEL_NONE) |-> (hostDataOut[BYTE_W-1:0] == '1)); // R9

endmodule

// File: rtl/ata_taskfile_decoder.sv
module ata_taskfile_decoder
  import tfdec_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ce1N,
  input  logic                ce2N,
  input  logic                regN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic                oeN,
  input  logic                weN,
  input  logic [2*BYTE_W-1:0] hostDataIn,
  output logic [2*BYTE_W-1:0] hostDataOut,
  output logic                hostDataOe,
  input  logic [BYTE_W-1:0]   errorIn,
  input  logic [BYTE_W-1:0]   statusIn,
  output logic [BYTE_W-1:0]   featuresOut,
  output logic [BYTE_W-1:0]   secCountOut,
  output logic [BYTE_W-1:0]   secNumOut,
  output logic [BYTE_W-1:0]   cylLowOut,
  output logic [BYTE_W-1:0]   cylHighOut,
  output logic [BYTE_W-1:0]   drvHeadOut,
  output logic [BYTE_W-1:0]   cmdOut,
  output logic                cmdStrobe,
  input  logic [2*BYTE_W-1:0] bufRdData,
  output logic                bufRdPop,
  output logic [2*BYTE_W-1:0] bufWrData,
  output logic                bufWrPush
);

  ctrl_t ctrl;

  tfdec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ce1N       (ce1N),
    .ce2N       (ce2N),
    .regN       (regN),
    .hostAddr   (hostAddr),
    .oeN        (oeN),
    .weN        (weN),
    .ctrl       (ctrl),
    .hostDataOe (hostDataOe)
  );

  tfdec_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .hostDataIn  (hostDataIn),
    .hostDataOut (hostDataOut),
    .errorIn     (errorIn),
    .statusIn    (statusIn),
    .featuresOut (featuresOut),
    .secCountOut (secCountOut),
    .secNumOut   (secNumOut),
    .cylLowOut   (cylLowOut),
    .cylHighOut  (cylHighOut),
    .drvHeadOut  (drvHeadOut),
    .cmdOut      (cmdOut),
    .cmdStrobe   (cmdStrobe),
    .bufRdData   (bufRdData),
    .bufRdPop    (bufRdPop),
    .bufWrData   (bufWrData),
    .bufWrPush   (bufWrPush)
  );

endmodule

// File: tb/ata_taskfile_decoder_tb.sv
module ata_taskfile_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ce1N = 1'b1, ce2N = 1'b1, regN = 1'b1;
  logic [10:0] hostAddr = '0;
  logic        oeN = 1'b1, weN = 1'b1;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut;
  logic        hostDataOe;
  logic [7:0]  errorIn = 8'h04, statusIn = 8'h50;
  logic [7:0]  featuresOut, secCountOut, secNumOut, cylLowOut, cylHighOut, drvHeadOut, cmdOut;
  logic        cmdStrobe, bufRdPop, bufWrPush;
  logic [15:0] bufRdData = '0, bufWrData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // results captured by the access tasks
  logic        pushSeen, cmdSeen, cmdAfter, popSeen, oeSeen;
  logic [15:0] pushData, rdWord;

  always #10 clk = ~clk;

  ata_taskfile_decoder u_dut (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2N(ce2N), .regN(regN),
    .hostAddr(hostAddr), .oeN(oeN), .weN(weN), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .errorIn(errorIn), .statusIn(statusIn),
    .featuresOut(featuresOut), .secCountOut(secCountOut), .secNumOut(secNumOut),
    .cylLowOut(cylLowOut), .cylHighOut(cylHighOut), .drvHeadOut(drvHeadOut),
    .cmdOut(cmdOut), .cmdStrobe(cmdStrobe),
    .bufRdData(bufRdData), .bufRdPop(bufRdPop),
    .bufWrData(bufWrData), .bufWrPush(bufWrPush)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeAcc(input logic c1, input logic c2, input logic [10:0] a, input logic [15:0] d);
    @(negedge clk);
    ce1N = c1; ce2N = c2; hostAddr = a; hostDataIn = d; weN = 1'b0;
    @(negedge clk);
    pushSeen = bufWrPush; pushData = bufWrData; cmdSeen = cmdStrobe;
    weN = 1'b1;
    @(negedge clk);
    cmdAfter = cmdStrobe;
    ce1N = 1'b1; ce2N = 1'b1;
    @(negedge clk);
  endtask

  task automatic readAcc(input logic c1, input logic c2, input logic [10:0] a);
    @(negedge clk);
    ce1N = c1; ce2N = c2; hostAddr = a; oeN = 1'b0;
    @(negedge clk);
    rdWord = hostDataOut; oeSeen = hostDataOe;
    oeN = 1'b1;
    @(negedge clk);
    popSeen = bufRdPop;
    ce1N = 1'b1; ce2N = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 features", featuresOut, 0);
    chk("R10 seccount", secCountOut, 0);
    chk("R10 cmd", cmdOut, 0);
    chk("R10 drvhead", drvHeadOut, 0);
    chk("R10 strobes", {cmdStrobe, bufWrPush, bufRdPop, hostDataOe}, 0);
  endtask

  task automatic t_word_regs;
    writeAcc(0, 0, 11'h002, 16'hA53C);
    chk("R2 word seccount", secCountOut, 8'h3C);
    chk("R2 word secnum", secNumOut, 8'hA5);
    writeAcc(0, 0, 11'h004, 16'h1234);
    chk("R2 word cyl", {cylHighOut, cylLowOut}, 16'h1234);
    readAcc(0, 0, 11'h002);
    chk("R2 word read pair", rdWord, 16'hA53C);
    chk("R2 word read oe", oeSeen, 1);
    readAcc(0, 0, 11'h3F4);
    chk("R1 addr 9:4 ignored", rdWord, 16'h1234);
  endtask

  task automatic t_byte_regs;
    writeAcc(0, 1, 11'h006, 16'h00E0);
    chk("R3 byte drvhead", drvHeadOut, 8'hE0);
    readAcc(0, 1, 11'h003);
    chk("R3 byte read secnum", rdWord, 16'hFFA5);
    readAcc(0, 1, 11'h001);
    chk("R5 byte read error", rdWord, 16'hFF04);
    writeAcc(0, 1, 11'h001, 16'h0077);
    chk("R5 byte write features", featuresOut, 8'h77);
    readAcc(0, 1, 11'h007);
    chk("R5 byte read status", rdWord, 16'hFF50);
  endtask

  task automatic t_odd;
    writeAcc(1, 0, 11'h000, 16'h5500);
    chk("R4 odd 0 features", featuresOut, 8'h55);
    writeAcc(1, 0, 11'h005, 16'h9900);
    chk("R4 odd 5 cylhigh", cylHighOut, 8'h99);
    chk("R4 odd 5 cyllow kept", cylLowOut, 8'h34);
    readAcc(1, 0, 11'h003);
    chk("R4 odd read secnum", rdWord, 16'hA5FF);
    readAcc(1, 0, 11'h001);
    chk("R4 odd read error", rdWord, 16'h04FF);
    readAcc(1, 0, 11'h002);
    chk("R9 odd undecoded", rdWord, 16'hFFFF);
  endtask

  task automatic t_not_selected;
    regN = 1'b0;
    writeAcc(0, 0, 11'h002, 16'h0101);
    readAcc(0, 0, 11'h002);
    regN = 1'b1;
    chk("R1 attribute write ignored", {secNumOut, secCountOut}, 16'hA53C);
    chk("R1 attribute read no drive", oeSeen, 0);
    writeAcc(0, 0, 11'h402, 16'h0202);
    chk("R1 space bit write ignored", {secNumOut, secCountOut}, 16'hA53C);
    readAcc(0, 0, 11'h402);
    chk("R1 space bit no drive", oeSeen, 0);
    readAcc(1, 1, 11'h002);
    chk("R1 no enable no drive", oeSeen, 0);
  endtask

  task automatic t_word_data;
    bufRdData = 16'hBEEF;
    readAcc(0, 0, 11'h000);
    chk("R6 word data read", rdWord, 16'hBEEF);
    chk("R6 word data pop", popSeen, 1);
    readAcc(0, 0, 11'h008);
    chk("R6 mirror read", rdWord, 16'hBEEF);
    chk("R6 mirror pop", popSeen, 1);
    writeAcc(0, 0, 11'h008, 16'hCAFE);
    chk("R6 word push", pushSeen, 1);
    chk("R6 word push data", pushData, 16'hCAFE);
  endtask

  task automatic t_byte_data;
    writeAcc(0, 1, 11'h000, 16'h0011);
    chk("R7 first byte no push", pushSeen, 0);
    writeAcc(0, 1, 11'h009, 16'h0022);
    chk("R7 second byte push", pushSeen, 1);
    chk("R7 packed word", pushData, 16'h2211);
    bufRdData = 16'h3344;
    readAcc(0, 1, 11'h008);
    chk("R7 read low byte", rdWord, 16'hFF44);
    chk("R7 low byte no pop", popSeen, 0);
    readAcc(0, 1, 11'h000);
    chk("R7 read high byte", rdWord, 16'hFF33);
    chk("R7 high byte pop", popSeen, 1);
    writeAcc(1, 0, 11'h009, 16'h6600);
    chk("R7 odd first no push", pushSeen, 0);
    writeAcc(1, 0, 11'h009, 16'h7700);
    chk("R7 odd packed word", {15'd0, pushSeen, pushData}, {15'd0, 1'b1, 16'h7766});
  endtask

  task automatic t_cmd;
    writeAcc(0, 1, 11'h000, 16'h0001);
    writeAcc(0, 1, 11'h007, 16'h00EC);
    chk("R8 strobe", cmdSeen, 1);
    chk("R8 strobe one cycle", cmdAfter, 0);
    chk("R8 cmd value", cmdOut, 8'hEC);
    bufRdData = 16'h5A6B;
    readAcc(0, 1, 11'h000);
    chk("R8 toggle cleared", rdWord, 16'hFF6B);
    writeAcc(0, 0, 11'h006, 16'h20A0);
    chk("R8 word cmd strobe", cmdSeen, 1);
    chk("R8 word cmd pair", {cmdOut, drvHeadOut}, 16'h20A0);
    readAcc(0, 1, 11'h000);
    chk("R8 toggle cleared by word cmd", rdWord, 16'hFF6B);
  endtask

  task automatic t_undecoded;
    readAcc(0, 0, 11'h00A);
    chk("R9 word undecoded", rdWord, 16'hFFFF);
    chk("R9 word undecoded driven", oeSeen, 1);
    readAcc(0, 1, 11'h00C);
    chk("R9 byte undecoded", rdWord, 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_word_regs();
    t_byte_regs();
    t_odd();
    t_not_selected();
    t_word_data();
    t_byte_data();
    t_cmd();
    t_undecoded();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule